// File: doc/BRIEF.md
# Programmable CRC Engine with Input FIFO

This block computes a cyclic redundancy check over a stream of data words written by software over a 16-bit memory-mapped bus. Software chooses the generator polynomial, the polynomial length (1 to 32 bits), the data word width (8, 16 or 32 bits) and the order in which the bits of each word enter the shift register. These four settings are independent of one another. Data words go into a 16-byte FIFO. A serial engine takes one word at a time from the FIFO and folds it into the running result, one bit on each cycle in which the shift-rate enable is high.

The result register can be preset with a seed while the engine is idle. It reads back masked to the configured polynomial length. A single interrupt output signals either the FIFO running dry or the last queued word being fully shifted, depending on the selected mode. Software clears the interrupt by writing a 1 to its status bit. A typical session is: program the controls and the polynomial, preset the seed, set the start bit, stream in words, then wait for the interrupt and read the result.

Top module: `crc_engine`

## Requirements
- R1: The engine takes n = CTRL[4:0] + 1 as the polynomial length. For each data bit d it forms fb = d XOR result[n-1]. The new result is {result[30:0], fb} XOR (fb ? poly with bit 0 cleared : 0), with bits at or above n cleared. Bit 0 therefore always receives fb. For example, poly 0x1021, n = 16, seed 0xFFFF over the bytes "123456789" sent MSB first gives 0x29B1.
- R2: CTRL[12] sets the bit order within each word: 1 feeds the word least-significant bit first, 0 feeds it most-significant bit first.
- R3: CTRL[9:8] sets the data width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. For 8 and 16 bits, a write to DATA_LO (address 4) pushes the low bits of the written value. For 32 bits, a write to DATA_LO holds the low half and a write to DATA_HI (address 5) pushes {written value, held half}.
- R4: The FIFO holds 16 bytes, that is 16, 8 or 4 words for widths of 8, 16 and 32 bits. STATUS (address 1) bit 0 is empty and bit 1 is full. Full means that one more word of the current width does not fit.
- R5: A push while the FIFO is full is dropped and sets the sticky overflow flag, STATUS bit 2. Writing STATUS with bit 2 set clears the flag.
- R6: The engine loads a word only while CTRL[14] (start) is 1 and the FIFO is not empty. It waits without error while the FIFO is empty and resumes when a word arrives. A word in progress advances only on cycles with shift_ce high. STATUS bit 3 reads 1 while a word is in progress.
- R7: With CTRL[13] = 0, the interrupt flag is set when a word is taken from the FIFO and leaves it empty. With CTRL[13] = 1, the flag is set when the last bit of a word is shifted while the FIFO is empty. The flag is sticky, reads as STATUS bit 4 and drives irq. Writing STATUS with bit 4 set clears it.
- R8: Writes to RES_LO and RES_HI (addresses 6 and 7) preset the result only while no word is in progress. Such writes made while a word is in progress are ignored. Result bits at or above n read back as 0.
- R9: The register map is: CTRL at 0 (reads back as written), STATUS at 1, POLY_LO and POLY_HI at 2 and 3, DATA_LO and DATA_HI at 4 and 5, RES_LO and RES_HI at 6 and 7. After reset all registers are 0 and STATUS reads 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| shift_ce | input | 1 | Shift-rate enable: one bit is processed per enabled cycle |
| irq | output | 1 | Interrupt flag |

## Verification
A register write takes effect at the clock edge where it is sampled, and reads are combinational. A pushed word is loaded on the next edge, and that load pops the FIFO and raises the empty-mode interrupt. The result is final after 8, 16 or 32 further enabled cycles, and the completion interrupt is raised on that last edge. The bench drives on falling edges and samples one time unit after them. Before it checks a result, it polls STATUS until the FIFO is empty and the engine is idle. The interrupt checks sample at a fixed two cycles after the push, which falls within the 32-cycle shift window. The ignored-preset check waits one extra cycle after the push so that the write lands after the load.

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int FIFO_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        shift_ce,
  output logic        irq
);
  localparam int PW = $clog2(FIFO_BYTES);
  localparam int CW = PW + 1;

  logic [15:0] ctrl_q, stage_lo;
  logic [31:0] poly_q, crc_q, word_q, head, crc_next, mask;
  logic [7:0]  mem [FIFO_BYTES];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, bpw;
  logic [4:0]  bitcnt, dw_m1, plen;
  logic        busy_q, ovf_q, irq_q;
  logic        lsb, isel, start, full, empty, push, do_push, load, shift, last;
  logic        din, fb, res_wr, empty_evt, done_evt;
  logic [31:0] push_word;

  assign plen  = ctrl_q[4:0];
  assign lsb   = ctrl_q[12];
  assign isel  = ctrl_q[13];
  assign start = ctrl_q[14];

  always_comb begin
    case (ctrl_q[9:8])
      2'd0:    begin bpw = CW'(1); dw_m1 = 5'd7;  end
      2'd1:    begin bpw = CW'(2); dw_m1 = 5'd15; end
      default: begin bpw = CW'(4); dw_m1 = 5'd31; end
    endcase
  end

  assign mask  = 32'hFFFF_FFFF >> (5'd31 - plen);
  assign empty = (cnt == '0);
  assign full  = ({1'b0, cnt} + {1'b0, bpw}) > (CW+1)'(FIFO_BYTES);

  assign push = bus_wr && ((bus_addr == 3'd4 && !ctrl_q[9]) || (bus_addr == 3'd5 && ctrl_q[9]));
  assign push_word = (bus_addr == 3'd5) ? {bus_wdata, stage_lo} : {16'h0, bus_wdata};
  assign do_push = push && !full;
  assign res_wr  = bus_wr && (bus_addr[2:1] == 2'b11);

  assign load  = start && !busy_q && !empty;
  assign shift = busy_q && shift_ce;
  assign last  = shift && (bitcnt == dw_m1);

  always_comb
    for (int i = 0; i < 4; i++) head[8*i +: 8] = mem[rptr + PW'(i)];

  assign din = lsb ? word_q[bitcnt] : word_q[dw_m1 - bitcnt];
  assign fb  = din ^ crc_q[plen];
  assign crc_next = ({crc_q[30:0], fb} ^ ({32{fb}} & poly_q & 32'hFFFF_FFFE)) & mask;

  assign empty_evt = load && (cnt == bpw);
  assign done_evt  = last && empty;

  always_ff @(posedge clk)
    if (do_push)
      for (int i = 0; i < 4; i++)
        if (CW'(i) < bpw) mem[wptr + PW'(i)] <= push_word[8*i +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; stage_lo <= '0; poly_q <= '0; crc_q <= '0; word_q <= '0;
      wptr <= '0; rptr <= '0; cnt <= '0; bitcnt <= '0;
      busy_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          3'd0: ctrl_q <= bus_wdata;
          3'd1: begin
            if (bus_wdata[2]) ovf_q <= 1'b0;
            if (bus_wdata[4]) irq_q <= 1'b0;
          end
          3'd2: poly_q[15:0]  <= bus_wdata;
          3'd3: poly_q[31:16] <= bus_wdata;
          3'd4: stage_lo <= bus_wdata;
          3'd6: if (!busy_q) crc_q[15:0]  <= bus_wdata;
          3'd7: if (!busy_q) crc_q[31:16] <= bus_wdata;
          default: ;
        endcase
      end
      if (push && full) ovf_q <= 1'b1;
      if (do_push) wptr <= wptr + PW'(bpw);
      if (load) begin
        rptr   <= rptr + PW'(bpw);
        word_q <= head;
        bitcnt <= '0;
        busy_q <= 1'b1;
      end
      cnt <= cnt + (do_push ? bpw : '0) - (load ? bpw : '0);
      if (shift) begin
        crc_q  <= crc_next;
        bitcnt <= bitcnt + 5'd1;
        if (last) busy_q <= 1'b0;
      end
      if ((!isel && empty_evt) || (isel && done_evt)) irq_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = ctrl_q;
      3'd1: bus_rdata = {11'h0, irq_q, busy_q, ovf_q, full, empty};
      3'd2: bus_rdata = poly_q[15:0];
      3'd3: bus_rdata = poly_q[31:16];
      3'd4: bus_rdata = stage_lo;
      3'd5: bus_rdata = 16'h0;
      3'd6: bus_rdata = crc_q[15:0] & mask[15:0];
      default: bus_rdata = crc_q[31:16] & mask[31:16];
    endcase
  end

  assign irq = irq_q;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_BYTES));
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !load) |=> cnt == $past(cnt));
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(bus_wr && bus_addr == 3'd1 && bus_wdata[2])) |=> ovf_q);
  p_no_load_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy_q) |=> !busy_q);
  p_hold_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !shift_ce) |=> ($stable(crc_q) && $stable(bitcnt)));
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(bus_wr && bus_addr == 3'd1 && bus_wdata[4])) |=> irq_q);
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !res_wr) |=> $stable(crc_q));
endmodule

// File: tb/sim_crc_engine.sv
module sim_crc_engine;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, shift_ce = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;

  crc_engine u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .shift_ce, .irq);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_res(output logic [31:0] r);
    logic [15:0] lo, hi;
    rd(3'd6, lo); rd(3'd7, hi); r = {hi, lo};
  endtask

  task automatic cfg(int plen_m1, int wsel, bit lsb, bit isel, bit start, logic [31:0] poly);
    wr(3'd0, 16'(plen_m1 | (wsel << 8) | (int'(lsb) << 12) | (int'(isel) << 13) | (int'(start) << 14)));
    wr(3'd2, poly[15:0]); wr(3'd3, poly[31:16]);
    wr(3'd1, 16'h0014);
  endtask

  task automatic seed(logic [31:0] s);
    wr(3'd6, s[15:0]); wr(3'd7, s[31:16]);
  endtask

  task automatic wait_done();
    logic [15:0] st;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); rd(3'd1, st);
      if (st[0] && !st[3]) break;
    end
  endtask

  function automatic logic [31:0] ref_word(logic [31:0] c, logic [31:0] p, int n,
                                          logic [31:0] w, int dw, bit lsb);
    logic [31:0] m = 32'hFFFF_FFFF >> (32 - n);
    for (int b = 0; b < dw; b++) begin
      logic d = lsb ? w[b] : w[dw-1-b];
      logic f = d ^ c[n-1];
      c = {c[30:0], f};
      if (f) c = c ^ (p & 32'hFFFF_FFFE);
      c = c & m;
    end
    return c;
  endfunction

  task automatic t_reset();
    logic [15:0] st; logic [31:0] r;
    rd(3'd1, st); chk("R9 reset status", 32'(st), 32'h0001);
    rd_res(r);    chk("R9 reset result", r, 0);
    chk("R7 reset irq", 32'(irq), 0);
  endtask

  task automatic t_known();
    string s = "123456789"; logic [31:0] r, e;
    cfg(15, 0, 0, 1, 1, 32'h1021); seed(32'hFFFF);
    e = 32'hFFFF;
    for (int i = 0; i < 9; i++) begin
      wr(3'd4, 16'(s[i])); e = ref_word(e, 32'h1021, 16, 32'(s[i]), 8, 0);
    end
    wait_done(); rd_res(r);
    chk("R1 16-bit check value", r, 32'h29B1);
    chk("R1 16-bit model", r, e);
    cfg(31, 0, 0, 1, 1, 32'h04C1_1DB7); seed(32'hFFFF_FFFF);
    for (int i = 0; i < 9; i++) wr(3'd4, 16'(s[i]));
    wait_done(); rd_res(r);
    chk("R1 32-bit check value", r, 32'h0376_E6E7);
  endtask

  task automatic t_order32(bit lsb);
    logic [31:0] r, e = 32'h0;
    logic [31:0] w [2] = '{32'h1234_5678, 32'hCAFE_F00D};
    cfg(31, 2, lsb, 1, 1, 32'h04C1_1DB7); seed(0);
    foreach (w[i]) begin
      wr(3'd4, w[i][15:0]); wr(3'd5, w[i][31:16]);
      e = ref_word(e, 32'h04C1_1DB7, 32, w[i], 32, lsb);
    end
    wait_done(); rd_res(r);
    chk(lsb ? "R2 R3 32-bit LSB first" : "R2 R3 32-bit MSB first", r, e);
  endtask

  task automatic t_short16();
    logic [31:0] r, e;
    cfg(4, 1, 0, 1, 1, 32'h15); seed(32'hFFFF_FFFF);
    rd_res(r); chk("R8 masked preset readback", r, 32'h1F);
    e = ref_word(32'h1F, 32'h15, 5, 32'hBEEF, 16, 0);
    e = ref_word(e, 32'h15, 5, 32'h1234, 16, 0);
    wr(3'd4, 16'hBEEF); wr(3'd4, 16'h1234);
    wait_done(); rd_res(r);
    chk("R1 R3 5-bit poly 16-bit words", r, e);
  endtask

  task automatic t_full();
    logic [15:0] st; logic [31:0] r, e = 0;
    cfg(15, 0, 1, 1, 0, 32'h8005); seed(0);
    for (int i = 0; i < 15; i++) begin
      wr(3'd4, 16'(i * 7 + 3)); e = ref_word(e, 32'h8005, 16, 32'(i * 7 + 3), 8, 1);
    end
    rd(3'd1, st); chk("R4 not full at 15 bytes", 32'(st[1]), 0);
    wr(3'd4, 16'h5A); e = ref_word(e, 32'h8005, 16, 32'h5A, 8, 1);
    rd(3'd1, st); chk("R4 full at 16 bytes", 32'(st[2:0]), 32'b010);
    wr(3'd4, 16'hAA);
    rd(3'd1, st); chk("R5 overflow set on dropped push", 32'(st[2]), 1);
    wr(3'd1, 16'h0004);
    rd(3'd1, st); chk("R5 overflow cleared", 32'(st[2:0]), 32'b010);
    wr(3'd0, 16'h400F | 16'h1000);
    wait_done(); rd_res(r);
    chk("R5 dropped byte not in result", r, e);
    cfg(15, 1, 0, 1, 0, 32'h8005);
    for (int i = 0; i < 7; i++) wr(3'd4, 16'(i));
    rd(3'd1, st); chk("R4 16-bit not full at 7", 32'(st[1]), 0);
    wr(3'd4, 16'h7);
    rd(3'd1, st); chk("R4 16-bit full at 8", 32'(st[1]), 1);
    wr(3'd0, 16'h410F);
    wait_done();
  endtask

  task automatic t_irq(bit isel);
    logic [15:0] st;
    cfg(31, 2, 0, isel, 1, 32'h04C1_1DB7);
    rd(3'd1, st); chk("R7 irq clear", 32'(st[4]), 0);
    wr(3'd4, 16'h1111); wr(3'd5, 16'h2222);
    @(negedge clk); rd(3'd1, st);
    if (isel) chk("R7 done mode: no irq mid-shift", {st[4], st[3], irq}, 3'b010);
    else      chk("R7 empty mode: irq on pop", {st[4], st[3], irq}, 3'b111);
    wait_done(); rd(3'd1, st);
    chk("R7 irq after completion", {st[4], irq}, 2'b11);
    wr(3'd1, 16'h0010); rd(3'd1, st);
    chk("R7 irq cleared by write", {st[4], irq}, 2'b00);
  endtask

  task automatic t_busy_preset();
    logic [31:0] r, e;
    cfg(31, 2, 1, 1, 1, 32'h1EDC_6F41); seed(32'h0BAD_F00D);
    e = ref_word(32'h0BAD_F00D, 32'h1EDC_6F41, 32, 32'hA5A5_0F0F, 32, 1);
    wr(3'd4, 16'h0F0F); wr(3'd5, 16'hA5A5);
    @(negedge clk);
    wr(3'd6, 16'h0000); wr(3'd7, 16'h0000);
    wait_done(); rd_res(r);
    chk("R8 preset ignored while busy", r, e);
  endtask

  task automatic t_pause();
    logic [15:0] st; logic [31:0] r, e;
    cfg(15, 0, 0, 1, 1, 32'h1021); seed(32'h1D0F);
    shift_ce = 1'b0;
    wr(3'd4, 16'h31);
    repeat (10) @(negedge clk);
    rd(3'd1, st); chk("R6 word held busy with shift disabled", 32'(st[3]), 1);
    rd_res(r);    chk("R6 result frozen with shift disabled", r, 32'h1D0F);
    shift_ce = 1'b1;
    wait_done();
    repeat (20) @(negedge clk);
    rd(3'd1, st); chk("R6 idle waiting on empty FIFO", 32'(st[3:0]), 32'b0001);
    wr(3'd4, 16'h32);
    wait_done(); rd_res(r);
    e = ref_word(32'h1D0F, 32'h1021, 16, 32'h31, 8, 0);
    e = ref_word(e, 32'h1021, 16, 32'h32, 8, 0);
    chk("R6 resume after pause", r, e);
    wr(3'd0, 16'h000F);
    wr(3'd4, 16'h77);
    repeat (12) @(negedge clk);
    rd(3'd1, st); chk("R6 no load without start", 32'(st[3:0]), 32'b0000);
    wr(3'd0, 16'h400F); wait_done();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known();
    t_order32(1'b1);
    t_order32(1'b0);
    t_short16();
    t_full();
    t_irq(1'b0);
    t_irq(1'b1);
    t_busy_preset();
    t_pause();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule